// File: doc/BRIEF.md
# Descriptor Ring Tracker

This block keeps the bookkeeping for a circular ring of DMA descriptors held in system memory. It does not fetch or decode descriptors and moves no data. It only tracks four regions of the ring. The free region is where software may write new descriptors. The queued region has been handed to the engine. The completed region is finished but not yet given back. The released region has become free again. Software talks to it through a plain word-addressed register port. It sets the ring size and base address, reads the next free slot, hands descriptors over with an add count, and returns finished ones with a release count.

A run/stop control gates a simple processing model. Each `proc_strobe` while the channel runs retires the oldest queued descriptor into the completed region. `proc_iod` carries the interrupt-on-done flag, which is bit 27 of that descriptor's control word. A completion message pulse is raised when enough completed descriptors are waiting and at least one of them asked for it. Software can raise the threshold to mute messages while it drains the ring, then lower it again.

There is no streaming data path. All pins are plain control and status levels or single-cycle strobes, so no valid/ready back-pressure applies.

Top module: `dq_ring_tracker`

## Requirements
- R1: After reset the ring size reads 1024, and the allocation pointer, queued count, completed count, oldest-completed index and threshold are all 0. The channel is stopped (status bit 0 = 0), the error bit (status bit 1) is clear and no message pulse occurs.
- R2: Writing the size register (offset 0) sets the ring size to the written value, clamped to the range 1..4096. The write clears all pointers and counts. The size register reads back the value in effect.
- R3: The allocation register (offset 2) returns the next free slot index in bits 31:16. Every other bit reads 0.
- R4: Writing N to the add register (offset 5) queues N descriptors and advances the allocation pointer by N, modulo the ring size.
- R5: Writing 0 to the control register (offset 7) starts the channel, and any nonzero value stops it. A strobe while the channel is stopped changes nothing.
- R6: Each strobe while the channel runs and the queue is not empty moves one descriptor from queued to completed. A strobe with an empty queue has no effect.
- R7: The done register (offset 3) reports the completed, unreleased count in bits 14:0 and the index of the oldest completed descriptor in bits 28:16. Every other bit reads 0.
- R8: Writing N to the release register (offset 6) lowers the completed count by N and advances the oldest-completed index by N, modulo the ring size.
- R9: An add count larger than the free space, or a release count larger than the completed count, is cut down to the amount available. Either case sets the error bit, which stays set until reset.
- R10: A one-cycle pulse on `msg_pulse` is raised when three conditions hold: the completed count exceeds the threshold, a completion since the last release had its interrupt-on-done flag set, and no pulse has been raised since that release. Pulses never occur on two consecutive cycles.
- R11: The threshold register (offset 4) holds a 15-bit value and reads back only those bits. A threshold at or above the completed count suppresses pulses. Lowering it releases a pulse that was being held back.
- R12: Completions whose interrupt-on-done flag is 0 never make a pulse eligible.
- R13: The base address register (offset 1) stores and reads back a full 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Word offset of the write |
| reg_wdata | input | 32 | Write data |
| reg_rd_addr | input | 4 | Word offset of the read |
| reg_rdata | output | 32 | Read data, combinational from the read offset |
| proc_strobe | input | 1 | Retire one queued descriptor |
| proc_iod | input | 1 | Interrupt-on-done flag of the retiring descriptor |
| chan_active | output | 1 | Channel running |
| err_flag | output | 1 | Sticky clamp error |
| msg_pulse | output | 1 | Completion message pulse |

## Verification
The assertions assume that the write port carries at most one register write per cycle. They also assume that `proc_strobe` and `proc_iod` are meaningful only together, and that every write to the size register is intended to restart the ring. The stimulus drives every input on the falling edge and holds each write or strobe for exactly one cycle. Over-large add and release counts are issued on purpose, so the clamping paths run while the occupancy bounds are still checked.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam logic [3:0] A_SIZE   = 4'h0;
  localparam logic [3:0] A_BASE   = 4'h1;
  localparam logic [3:0] A_ALLOC  = 4'h2;
  localparam logic [3:0] A_DONE   = 4'h3;
  localparam logic [3:0] A_THRESH = 4'h4;
  localparam logic [3:0] A_ADD    = 4'h5;
  localparam logic [3:0] A_REL    = 4'h6;
  localparam logic [3:0] A_CTRL   = 4'h7;
  localparam int unsigned THR_W     = 15;
  localparam int unsigned PTR_LSB   = 16;
endpackage

// File: rtl/ring_ptr_adv.sv
module ring_ptr_adv #(
  parameter int W = 13
) (
  input  logic [W-1:0] ptr,
  input  logic [W-1:0] step,
  input  logic [W-1:0] size,
  output logic [W-1:0] nxt
);
  logic [W:0] sum;
  logic [W:0] wrapped;
  always_comb begin
    sum     = {1'b0, ptr} + {1'b0, step};
    wrapped = sum - {1'b0, size};
    nxt     = (sum >= {1'b0, size}) ? wrapped[W-1:0] : sum[W-1:0];
  end
endmodule

// File: rtl/cnt_clamp.sv
module cnt_clamp #(
  parameter int W = 13
) (
  input  logic [31:0]  req,
  input  logic [W-1:0] avail,
  output logic [W-1:0] grant,
  output logic         over
);
  always_comb begin
    over  = req > 32'(avail);
    grant = over ? avail : req[W-1:0];
  end
endmodule

// File: rtl/msg_gate.sv
module msg_gate import dq_pkg::*; #(
  parameter int CW = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic             iod,
  input  logic             release_wr,
  input  logic [CW-1:0]    pending,
  input  logic [THR_W-1:0] thresh,
  output logic             msg_pulse
);
  logic iod_seen_q, outst_q, msg_q, fire;

  always_comb
    fire = (THR_W'(pending) > thresh) && iod_seen_q && !outst_q && !release_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iod_seen_q <= 1'b0;
      outst_q    <= 1'b0;
      msg_q      <= 1'b0;
    end else begin
      msg_q <= fire;
      if (release_wr) begin
        iod_seen_q <= retire && iod;
        outst_q    <= 1'b0;
      end else begin
        if (retire && iod) iod_seen_q <= 1'b1;
        if (fire)          outst_q    <= 1'b1;
      end
    end
  end

  assign msg_pulse = msg_q;

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_q |=> !msg_q);
endmodule

// File: rtl/dq_ring_tracker.sv
module dq_ring_tracker import dq_pkg::*; #(
  parameter int MAX_LOG     = 12,
  parameter int DEF_ENTRIES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [3:0]  reg_wr_addr,
  input  logic [31:0] reg_wdata,
  input  logic [3:0]  reg_rd_addr,
  output logic [31:0] reg_rdata,
  input  logic        proc_strobe,
  input  logic        proc_iod,
  output logic        chan_active,
  output logic        err_flag,
  output logic        msg_pulse
);
  localparam int PTR_W       = MAX_LOG + 1;
  localparam int MAX_ENTRIES = 1 << MAX_LOG;

  logic [PTR_W-1:0] size_q, alloc_q, rdptr_q, queued_q, pending_q;
  logic [31:0]      base_q;
  logic [THR_W-1:0] thresh_q;
  logic             active_q, err_q;

  logic wr_size, wr_base, wr_thr, wr_add, wr_rel, wr_ctrl;
  logic [PTR_W-1:0] free_cnt, add_n, rel_n, add_eff, rel_eff;
  logic [PTR_W-1:0] alloc_nxt, rdptr_nxt, size_new;
  logic add_over, rel_over, retire;

  always_comb begin
    wr_size  = reg_wr_en && (reg_wr_addr == A_SIZE);
    wr_base  = reg_wr_en && (reg_wr_addr == A_BASE);
    wr_thr   = reg_wr_en && (reg_wr_addr == A_THRESH);
    wr_add   = reg_wr_en && (reg_wr_addr == A_ADD);
    wr_rel   = reg_wr_en && (reg_wr_addr == A_REL);
    wr_ctrl  = reg_wr_en && (reg_wr_addr == A_CTRL);
    free_cnt = size_q - queued_q - pending_q;
    add_eff  = wr_add ? add_n : '0;
    rel_eff  = wr_rel ? rel_n : '0;
    retire   = proc_strobe && active_q && (queued_q != '0);
    if (reg_wdata == 32'd0)
      size_new = PTR_W'(1);
    else if (reg_wdata > 32'(MAX_ENTRIES))
      size_new = PTR_W'(MAX_ENTRIES);
    else
      size_new = reg_wdata[PTR_W-1:0];
  end

  cnt_clamp #(.W(PTR_W)) u_add_clamp (
    .req(reg_wdata), .avail(free_cnt), .grant(add_n), .over(add_over));
  cnt_clamp #(.W(PTR_W)) u_rel_clamp (
    .req(reg_wdata), .avail(pending_q), .grant(rel_n), .over(rel_over));

  ring_ptr_adv #(.W(PTR_W)) u_alloc_adv (
    .ptr(alloc_q), .step(add_eff), .size(size_q), .nxt(alloc_nxt));
  ring_ptr_adv #(.W(PTR_W)) u_rd_adv (
    .ptr(rdptr_q), .step(rel_eff), .size(size_q), .nxt(rdptr_nxt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q    <= PTR_W'(DEF_ENTRIES);
      base_q    <= '0;
      alloc_q   <= '0;
      rdptr_q   <= '0;
      queued_q  <= '0;
      pending_q <= '0;
      thresh_q  <= '0;
      active_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (wr_base) base_q   <= reg_wdata;
      if (wr_thr)  thresh_q <= reg_wdata[THR_W-1:0];
      if (wr_ctrl) active_q <= (reg_wdata == 32'd0);
      if ((wr_add && add_over) || (wr_rel && rel_over)) err_q <= 1'b1;
      if (wr_size) begin
        size_q    <= size_new;
        alloc_q   <= '0;
        rdptr_q   <= '0;
        queued_q  <= '0;
        pending_q <= '0;
      end else begin
        alloc_q   <= alloc_nxt;
        rdptr_q   <= rdptr_nxt;
        queued_q  <= queued_q + add_eff - PTR_W'(retire);
        pending_q <= pending_q + PTR_W'(retire) - rel_eff;
      end
    end
  end

  always_comb begin
    case (reg_rd_addr)
      A_SIZE:   reg_rdata = 32'(size_q);
      A_BASE:   reg_rdata = base_q;
      A_ALLOC:  reg_rdata = 32'(alloc_q) << PTR_LSB;
      A_DONE:   reg_rdata = (32'(rdptr_q) << PTR_LSB) | 32'(pending_q);
      A_THRESH: reg_rdata = 32'(thresh_q);
      A_CTRL:   reg_rdata = {30'd0, err_q, active_q};
      default:  reg_rdata = 32'd0;
    endcase
  end

  msg_gate #(.CW(PTR_W)) u_msg (
    .clk(clk), .rst_n(rst_n),
    .retire(retire && !wr_size), .iod(proc_iod),
    .release_wr(wr_rel || wr_size),
    .pending(pending_q), .thresh(thresh_q),
    .msg_pulse(msg_pulse));

  assign chan_active = active_q;
  assign err_flag    = err_q;

  // R4
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, queued_q} + {1'b0, pending_q}) <= {1'b0, size_q});
  // R3
  alloc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_q < size_q);
  // R8
  rdptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdptr_q < size_q);
  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !wr_size && !wr_rel) |=> $stable(pending_q));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: tb/dq_ring_tracker_tb.sv
module dq_ring_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_rd_addr = '0;
  logic [31:0] reg_rdata;
  logic        proc_strobe = 1'b0;
  logic        proc_iod = 1'b0;
  logic        chan_active, err_flag, msg_pulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dq_ring_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .proc_strobe(proc_strobe), .proc_iod(proc_iod), .chan_active(chan_active),
    .err_flag(err_flag), .msg_pulse(msg_pulse));

  always @(negedge clk) if (rst_n && msg_pulse) pulses++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr_en = 1'b0; proc_strobe = 1'b0; proc_iod = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pulses = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_rd_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic strobe(input logic iod);
    @(negedge clk);
    proc_strobe = 1'b1; proc_iod = iod;
    @(negedge clk);
    proc_strobe = 1'b0; proc_iod = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    repeat (3) @(negedge clk);
    rd(4'h0, v); check("R1 size", v, 32'd1024);
    rd(4'h2, v); check("R1 alloc", v, 32'd0);
    rd(4'h3, v); check("R1 done", v, 32'd0);
    rd(4'h4, v); check("R1 thresh", v, 32'd0);
    rd(4'h7, v); check("R1 status", v, 32'd0);
    check("R1 pulses", pulses, 0);
  endtask

  task automatic t_size_base();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'd0);    rd(4'h0, v); check("R2 size zero", v, 32'd1);
    wr(4'h0, 32'd5000); rd(4'h0, v); check("R2 size max", v, 32'd4096);
    wr(4'h0, 32'd8);
    wr(4'h5, 32'd3);
    wr(4'h0, 32'd8);    rd(4'h0, v); check("R2 size 8", v, 32'd8);
    rd(4'h2, v); check("R2 alloc cleared", v, 32'd0);
    wr(4'h1, 32'hDEADBEEF); rd(4'h1, v); check("R13 base", v, 32'hDEADBEEF);
  endtask

  task automatic t_add();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'd8);
    wr(4'h5, 32'd3);
    rd(4'h2, v); check("R3 R4 alloc 3", v, 32'h0003_0000);
    rd(4'h7, v); check("R9 no err", v, 32'd0);
    wr(4'h5, 32'd6);
    rd(4'h2, v); check("R4 R9 alloc wrap", v, 32'd0);
    rd(4'h7, v); check("R9 add clamp err", v, 32'd2);
  endtask

  task automatic t_stop_run();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'd8);
    wr(4'h5, 32'd2);
    strobe(1'b0);
    rd(4'h3, v); check("R5 stopped strobe", v, 32'd0);
    wr(4'h7, 32'd0);
    rd(4'h7, v); check("R5 active", v, 32'd1);
    strobe(1'b0);
    rd(4'h3, v); check("R6 one retire", v, 32'd1);
    strobe(1'b0); strobe(1'b0);
    rd(4'h3, v); check("R6 empty queue", v, 32'd2);
    wr(4'h7, 32'd1);
    rd(4'h7, v); check("R5 stopped", v, 32'd0);
  endtask

  task automatic t_release();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'd4);
    wr(4'h5, 32'd4);
    wr(4'h7, 32'd0);
    for (int i = 0; i < 4; i++) strobe(1'b0);
    rd(4'h3, v); check("R7 done full", v, 32'd4);
    wr(4'h6, 32'd3);
    rd(4'h3, v); check("R7 R8 release 3", v, 32'h0003_0001);
    wr(4'h5, 32'd3);
    rd(4'h2, v); check("R4 alloc after wrap", v, 32'h0003_0000);
    for (int i = 0; i < 3; i++) strobe(1'b0);
    wr(4'h6, 32'd2);
    rd(4'h3, v); check("R8 rdptr wrap", v, 32'h0001_0002);
    rd(4'h7, v); check("R9 no err yet", v, 32'd1);
    wr(4'h6, 32'd5);
    rd(4'h3, v); check("R8 R9 release clamp", v, 32'h0003_0000);
    rd(4'h7, v); check("R9 release err", v, 32'd3);
  endtask

  task automatic t_msg();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R11 thresh width", v, 32'h7FFF);
    wr(4'h0, 32'd16);
    wr(4'h4, 32'd16);
    wr(4'h5, 32'd4);
    wr(4'h7, 32'd0);
    strobe(1'b1); strobe(1'b1);
    repeat (4) @(negedge clk);
    check("R11 muted", pulses, 0);
    wr(4'h4, 32'd0);
    repeat (4) @(negedge clk);
    check("R10 R11 pulse", pulses, 1);
    strobe(1'b1);
    repeat (4) @(negedge clk);
    check("R10 outstanding", pulses, 1);
    wr(4'h6, 32'd1);
    repeat (4) @(negedge clk);
    check("R10 after release", pulses, 1);
    strobe(1'b1);
    repeat (4) @(negedge clk);
    check("R10 new window", pulses, 2);
  endtask

  task automatic t_no_iod();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'd16);
    wr(4'h5, 32'd2);
    wr(4'h7, 32'd0);
    strobe(1'b0); strobe(1'b0);
    repeat (5) @(negedge clk);
    check("R12 no pulse", pulses, 0);
    rd(4'h3, v); check("R12 pending", v, 32'd2);
  endtask

  initial begin
    t_reset();
    t_size_base();
    t_add();
    t_stop_run();
    t_release();
    t_msg();
    t_no_iod();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule